// File: doc/BRIEF.md
# Trap Entry Sequencer

This block sits at the retire edge of an in-order core. On each instruction boundary it looks at three things: a pending synchronous exception, an external interrupt request, and the vector the interrupt controller offers for the current priority mask. From these it picks at most one event. It then performs the architectural entry: it saves the status word, the program counter and the stack register, raises the privileged and block bits, and computes the handler address.

The handler address depends on the event code. Reset-class codes go to a fixed boot address. TLB-miss codes go to a dedicated offset from the vector base. Interrupts go to a separate offset, and every other exception goes to a general offset.

The boundary strobe is the block's only data-carrying handshake. It behaves as a valid with an implied ready that is always high: there is no back-pressure, and every boundary strobe is evaluated in the cycle it is seen. All state updates commit at the clock edge that samples the strobe. A one-cycle `done_o` pulse follows in the next cycle.

Top module: `trap_entry_seq`

## Requirements
- R1: When `exc_valid_i` and `irq_req_i` are both high at a boundary, the exception is taken (`is_irq_o`=0) and INTEVT is left unchanged.
- R2: With SR bit 28 (block bit) set, any exception code other than 0x1E0 is taken as code 0x000. Code 0x1E0 is taken unchanged.
- R3: While SR bit 28 is set, an interrupt request is not taken and no output changes, unless `halt_wake_i` is high, in which case it is taken.
- R4: `irq_mask_o` always equals SR bits 7:4. When the controller reports `irq_none_i`=1, no interrupt is taken and no output changes.
- R5: On any taken event, SSR holds the old SR, SGR holds R15, and the new SR is the old SR with bits 30, 29 and 28 set.
- R6: When `dslot_i` is high at a taken event, SPC is PC−2 (otherwise PC), and `dslot_clr_o` pulses together with `done_o`.
- R7: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15, force SR bits 7:4 to 0xF, and set the new PC to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 set the new PC to VBR+0x400. All other exception codes outside R7 set it to VBR+0x100.
- R9: For exception code 0x160, SPC is advanced by 2 after the delay-slot adjustment of R6.
- R10: An exception loads EXPEVT with its final code and leaves INTEVT alone. An interrupt loads INTEVT with the vector, sets the new PC to VBR+0x600, and leaves EXPEVT alone.
- R11: Outputs change only at the edge after a boundary strobe that takes an event. `done_o` is high for exactly that following cycle. Without `boundary_i`, nothing is taken. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe (valid, always accepted) |
| exc_valid_i | input | 1 | An exception is pending |
| exc_code_i | input | CODE_W | Pending exception code |
| irq_req_i | input | 1 | External interrupt request |
| halt_wake_i | input | 1 | Core is waking from a halt |
| irq_mask_o | output | 4 | Current priority mask to the interrupt controller |
| irq_vec_i | input | CODE_W | Vector offered by the interrupt controller |
| irq_none_i | input | 1 | Controller has no vector above the mask |
| sr_i | input | XLEN | Current status register |
| pc_i | input | XLEN | Current program counter |
| r15_i | input | XLEN | Current general register 15 |
| vbr_i | input | XLEN | Vector base |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| done_o | output | 1 | One-cycle pulse after an event is committed |
| is_irq_o | output | 1 | Last committed event was an interrupt |
| dslot_clr_o | output | 1 | Clear the delay-slot flags (pulses with done_o) |
| sr_o | output | XLEN | New status register |
| ssr_o | output | XLEN | Saved status register |
| spc_o | output | XLEN | Saved program counter |
| sgr_o | output | XLEN | Saved R15 |
| expevt_o | output | CODE_W | Last exception code |
| intevt_o | output | CODE_W | Last interrupt vector |
| pc_o | output | XLEN | Handler address |

## Verification
A wrong arbitration decision shows up one edge after the boundary strobe. It appears either as a missing or unexpected `done_o` pulse, or as the wrong one of EXPEVT and INTEVT moving. A wrong address or SR computation stays latched in `pc_o`, `spc_o` or `sr_o` until the next taken event, so every vector compares all outputs in the cycle after its strobe. Masked and ignored cases are checked by confirming that `done_o` stays low and that every output keeps its earlier value.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EXC  = 2'd1,
    EV_IRQ  = 2'd2
  } ev_kind_e;

  // status word bit positions
  localparam int SR_MD_BIT   = 30;
  localparam int SR_RB_BIT   = 29;
  localparam int SR_BL_BIT   = 28;
  localparam int SR_FD_BIT   = 15;
  localparam int SR_MASK_LSB = 4;
  localparam int MASK_W      = 4;

  // event codes with special handling
  localparam int CODE_RESET   = 'h000;
  localparam int CODE_MRESET  = 'h020;
  localparam int CODE_TLBMULT = 'h140;
  localparam int CODE_MISS_RD = 'h040;
  localparam int CODE_MISS_WR = 'h060;
  localparam int CODE_TRAP    = 'h160;
  localparam int CODE_KEEP_BL = 'h1E0;

  // handler offsets from vector base
  localparam int OFS_GENERAL = 'h100;
  localparam int OFS_MISS    = 'h400;
  localparam int OFS_IRQ     = 'h600;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              halt_wake,
  input  logic              irq_none,
  input  logic              blocked,
  output ev_kind_e          kind,
  output logic [CODE_W-1:0] code
);

  logic irq_ok;

  always_comb begin
    irq_ok = irq_req && !irq_none && (!blocked || halt_wake);
    kind   = EV_NONE;
    code   = exc_code;
    if (exc_valid) begin
      kind = EV_EXC;
      if (blocked && exc_code != CODE_W'(CODE_KEEP_BL))
        code = CODE_W'(CODE_RESET);
    end else if (irq_ok) begin
      kind = EV_IRQ;
    end
  end

endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CODE_W   = 12,
  parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000
) (
  input  ev_kind_e          kind,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   sr,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   vbr,
  input  logic              dslot,
  output logic [XLEN-1:0]   sr_new,
  output logic [XLEN-1:0]   spc_new,
  output logic [XLEN-1:0]   pc_new
);

  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  always_comb begin
    sr_new = sr;
    sr_new[SR_MD_BIT] = 1'b1;
    sr_new[SR_RB_BIT] = 1'b1;
    sr_new[SR_BL_BIT] = 1'b1;
    spc_new = dslot ? pc - STEP : pc;
    pc_new  = vbr + XLEN'(OFS_GENERAL);
    if (kind == EV_IRQ) begin
      pc_new = vbr + XLEN'(OFS_IRQ);
    end else if (kind == EV_EXC) begin
      case (code)
        CODE_W'(CODE_RESET), CODE_W'(CODE_MRESET), CODE_W'(CODE_TLBMULT): begin
          sr_new[SR_FD_BIT] = 1'b0;
          sr_new[SR_MASK_LSB +: MASK_W] = '1;
          pc_new = RESET_PC;
        end
        CODE_W'(CODE_MISS_RD), CODE_W'(CODE_MISS_WR):
          pc_new = vbr + XLEN'(OFS_MISS);
        CODE_W'(CODE_TRAP):
          spc_new = spc_new + STEP;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CODE_W   = 12,
  parameter logic [XLEN-1:0] RESET_PC = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic              halt_wake_i,
  output logic [3:0]        irq_mask_o,
  input  logic [CODE_W-1:0] irq_vec_i,
  input  logic              irq_none_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   r15_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              dslot_i,
  output logic              done_o,
  output logic              is_irq_o,
  output logic              dslot_clr_o,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic [XLEN-1:0]   pc_o
);

  ev_kind_e          kind;
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   sr_new, spc_new, pc_new;
  logic              commit;

  assign irq_mask_o = sr_i[SR_MASK_LSB +: MASK_W];

  trap_arbiter #(.CODE_W(CODE_W)) arb_i (
    .exc_valid (exc_valid_i),
    .exc_code  (exc_code_i),
    .irq_req   (irq_req_i),
    .halt_wake (halt_wake_i),
    .irq_none  (irq_none_i),
    .blocked   (sr_i[SR_BL_BIT]),
    .kind      (kind),
    .code      (code)
  );

  trap_target #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_PC(RESET_PC)) tgt_i (
    .kind    (kind),
    .code    (code),
    .sr      (sr_i),
    .pc      (pc_i),
    .vbr     (vbr_i),
    .dslot   (dslot_i),
    .sr_new  (sr_new),
    .spc_new (spc_new),
    .pc_new  (pc_new)
  );

  assign commit = boundary_i && (kind != EV_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o      <= 1'b0;
      is_irq_o    <= 1'b0;
      dslot_clr_o <= 1'b0;
      sr_o        <= '0;
      ssr_o       <= '0;
      spc_o       <= '0;
      sgr_o       <= '0;
      expevt_o    <= '0;
      intevt_o    <= '0;
      pc_o        <= '0;
    end else begin
      done_o      <= commit;
      dslot_clr_o <= commit && dslot_i;
      if (commit) begin
        is_irq_o <= (kind == EV_IRQ);
        sr_o     <= sr_new;
        ssr_o    <= sr_i;
        spc_o    <= spc_new;
        sgr_o    <= r15_i;
        pc_o     <= pc_new;
        if (kind == EV_IRQ) intevt_o <= irq_vec_i;
        else                expevt_o <= code;
      end
    end
  end

endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic              exc_valid_i,
  input logic              irq_req_i,
  input logic              halt_wake_i,
  input logic [3:0]        irq_mask_o,
  input logic [XLEN-1:0]   sr_i,
  input logic              done_o,
  input logic              is_irq_o,
  input logic              dslot_clr_o,
  input logic [XLEN-1:0]   sr_o,
  input logic [XLEN-1:0]   pc_o,
  input logic [CODE_W-1:0] expevt_o,
  input logic [CODE_W-1:0] intevt_o
);

  // R1
  excp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && exc_valid_i |=> done_o && !is_irq_o && $stable(intevt_o));

  // R3
  blk_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i && !exc_valid_i && irq_req_i && sr_i[28] && !halt_wake_i |=> !done_o);

  // R4
  mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask_o == sr_i[7:4]);

  // R5
  sr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> sr_o[30] && sr_o[29] && sr_o[28]);

  // R7
  boot_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !is_irq_o && expevt_o == '0 |-> pc_o == 32'hA000_0000 && sr_o[7:4] == 4'hF);

  // R6
  dclr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_clr_o |-> done_o);

  // R11
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(boundary_i));

  // R11
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(pc_o) && $stable(sr_o));

endmodule

bind trap_entry_seq trap_entry_seq_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .boundary_i  (boundary_i),
  .exc_valid_i (exc_valid_i),
  .irq_req_i   (irq_req_i),
  .halt_wake_i (halt_wake_i),
  .irq_mask_o  (irq_mask_o),
  .sr_i        (sr_i),
  .done_o      (done_o),
  .is_irq_o    (is_irq_o),
  .dslot_clr_o (dslot_clr_o),
  .sr_o        (sr_o),
  .pc_o        (pc_o),
  .expevt_o    (expevt_o),
  .intevt_o    (intevt_o)
);

// File: tb/trap_entry_seq_tb_top.sv
module trap_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 1'b0, exc_valid_i = 1'b0, irq_req_i = 1'b0;
  logic        halt_wake_i = 1'b0, irq_none_i = 1'b0, dslot_i = 1'b0;
  logic [11:0] exc_code_i = '0, irq_vec_i = '0;
  logic [31:0] sr_i = '0, pc_i = '0, r15_i = '0, vbr_i = '0;
  logic [3:0]  irq_mask_o;
  logic        done_o, is_irq_o, dslot_clr_o;
  logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
  logic [11:0] expevt_o, intevt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  trap_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
    .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .irq_req_i(irq_req_i), .halt_wake_i(halt_wake_i),
    .irq_mask_o(irq_mask_o), .irq_vec_i(irq_vec_i), .irq_none_i(irq_none_i),
    .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i), .vbr_i(vbr_i), .dslot_i(dslot_i),
    .done_o(done_o), .is_irq_o(is_irq_o), .dslot_clr_o(dslot_clr_o),
    .sr_o(sr_o), .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o),
    .expevt_o(expevt_o), .intevt_o(intevt_o), .pc_o(pc_o)
  );

  typedef struct {
    string       req;
    bit          done, isirq, dclr;
    logic [31:0] sr, ssr, spc, sgr, pc;
    logic [11:0] expevt, intevt;
  } exp_t;

  exp_t exp_q[$];
  exp_t held;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // driver: applies one boundary strobe and predicts the result
  task automatic apply(string req, bit bnd, bit ev, logic [11:0] code, bit irq,
                       bit wake, logic [11:0] vec, bit none, logic [31:0] sr,
                       logic [31:0] pc, logic [31:0] r15, logic [31:0] vbr, bit ds);
    exp_t e;
    logic [11:0] c;
    bit take_exc, take_irq;
    @(negedge clk);
    boundary_i = bnd; exc_valid_i = ev; exc_code_i = code; irq_req_i = irq;
    halt_wake_i = wake; irq_vec_i = vec; irq_none_i = none; sr_i = sr;
    pc_i = pc; r15_i = r15; vbr_i = vbr; dslot_i = ds;
    #1;
    chk("R4", "irq_mask_o", 32'(irq_mask_o), 32'(sr[7:4]));
    c = (sr[28] && code != 12'h1E0) ? 12'h000 : code;
    take_exc = bnd && ev;
    take_irq = bnd && !ev && irq && !none && (!sr[28] || wake);
    e = held;
    e.req = req; e.done = 0; e.dclr = 0;
    if (take_exc || take_irq) begin
      e.done = 1; e.dclr = ds; e.isirq = take_irq;
      e.ssr = sr; e.sgr = r15;
      e.sr = sr | 32'h7000_0000;
      e.spc = ds ? pc - 2 : pc;
      if (take_irq) begin
        e.intevt = vec; e.pc = vbr + 32'h600;
      end else begin
        e.expevt = c; e.pc = vbr + 32'h100;
        if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin
          e.sr[15] = 1'b0; e.sr[7:4] = 4'hF; e.pc = 32'hA000_0000;
        end else if (c == 12'h040 || c == 12'h060) begin
          e.pc = vbr + 32'h400;
        end else if (c == 12'h160) begin
          e.spc = e.spc + 2;
        end
      end
    end
    exp_q.push_back(e);
    held = e;
    @(negedge clk);
    boundary_i = 1'b0;
  endtask

  // monitor: compares just after the committing edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "done_o", 32'(done_o), 32'(e.done));
        chk(e.req, "dslot_clr_o", 32'(dslot_clr_o), 32'(e.dclr));
        chk(e.req, "is_irq_o", 32'(is_irq_o), 32'(e.isirq));
        chk(e.req, "sr_o", sr_o, e.sr);
        chk(e.req, "ssr_o", ssr_o, e.ssr);
        chk(e.req, "spc_o", spc_o, e.spc);
        chk(e.req, "sgr_o", sgr_o, e.sgr);
        chk(e.req, "pc_o", pc_o, e.pc);
        chk(e.req, "expevt_o", 32'(expevt_o), 32'(e.expevt));
        chk(e.req, "intevt_o", 32'(intevt_o), 32'(e.intevt));
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    held = '{req: "R11", done: 0, isirq: 0, dclr: 0, sr: 0, ssr: 0, spc: 0,
             sgr: 0, pc: 0, expevt: 0, intevt: 0};
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    chk("R11", "reset done_o", 32'(done_o), 0);
    chk("R11", "reset pc_o", pc_o, 0);
    chk("R11", "reset sr_o", sr_o, 0);
    @(negedge clk); rst_n = 1'b1;
    // R8 R10 general exception
    apply("R8", 1, 1, 12'h0A0, 0, 0, 0, 0, 32'h0000_00F0, 32'h0C00_1000, 32'h1111_2222, 32'h8C00_0000, 0);
    // R1 exception beats interrupt
    apply("R1", 1, 1, 12'h0E0, 1, 0, 12'h320, 0, 32'h0000_0030, 32'h0C00_2000, 32'h3333_4444, 32'h8C00_0000, 0);
    // R2 blocked exception becomes reset, R7 boot address
    apply("R2", 1, 1, 12'h0E0, 0, 0, 0, 0, 32'h1000_8010, 32'h0C00_3000, 32'h5, 32'h8C00_0000, 0);
    // R2 code 0x1E0 survives the block bit
    apply("R2", 1, 1, 12'h1E0, 0, 0, 0, 0, 32'h1000_0000, 32'h0C00_3100, 32'h6, 32'h8C00_0000, 0);
    // R10 interrupt entry
    apply("R10", 1, 0, 0, 1, 0, 12'h3C0, 0, 32'h0000_8020, 32'h0C00_4000, 32'h7, 32'h9000_0000, 0);
    // R3 interrupt ignored while blocked
    apply("R3", 1, 0, 0, 1, 0, 12'h400, 0, 32'h1000_0000, 32'h0C00_5000, 32'h8, 32'h9000_0000, 0);
    // R3 halt wake lets it through
    apply("R3", 1, 0, 0, 1, 1, 12'h420, 0, 32'h1000_0000, 32'h0C00_5100, 32'h9, 32'h9000_0000, 0);
    // R4 controller reports no vector
    apply("R4", 1, 0, 0, 1, 0, 12'h440, 1, 32'h0000_00A0, 32'h0C00_6000, 32'hA, 32'h9000_0000, 0);
    // R8 TLB miss codes
    apply("R8", 1, 1, 12'h040, 0, 0, 0, 0, 32'h0, 32'h0C00_7000, 32'hB, 32'h8800_0000, 0);
    apply("R8", 1, 1, 12'h060, 0, 0, 0, 0, 32'h0, 32'h0C00_7100, 32'hC, 32'h8800_0000, 0);
    // R6 delay slot rewind
    apply("R6", 1, 1, 12'h0A0, 0, 0, 0, 0, 32'h0, 32'h0C00_8000, 32'hD, 32'h8800_0000, 1);
    // R9 trap advance, alone and in a delay slot
    apply("R9", 1, 1, 12'h160, 0, 0, 0, 0, 32'h0, 32'h0C00_9000, 32'hE, 32'h8800_0000, 0);
    apply("R9", 1, 1, 12'h160, 0, 0, 0, 0, 32'h0, 32'h0C00_9100, 32'hF, 32'h8800_0000, 1);
    // R7 other reset-class codes
    apply("R7", 1, 1, 12'h020, 0, 0, 0, 0, 32'h0000_8000, 32'h0C00_A000, 32'h10, 32'h8800_0000, 0);
    apply("R7", 1, 1, 12'h140, 0, 0, 0, 0, 32'h0000_8050, 32'h0C00_A100, 32'h11, 32'h8800_0000, 1);
    // R11 no strobe, nothing taken
    apply("R11", 0, 1, 12'h0A0, 1, 0, 12'h500, 0, 32'h0, 32'h0C00_B000, 32'h12, 32'h8800_0000, 0);
    // R5 interrupt with delay slot after quiet cycle
    apply("R5", 1, 0, 0, 1, 0, 12'h5A0, 0, 32'h0000_0001, 32'h0C00_C000, 32'h13, 32'hA000_1000, 1);
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule